// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a bank of maskable peripheral request lines and seven non-maskable trap lines and turns them into a single request toward a processor. Each request line sets a pending flag. Each maskable source also has an enable bit and a 3-bit priority, both set through a small configuration port. The same port loads a table of 24-bit handler start addresses, one for each vector. The block presents the winning vector number, its handler address and the level it won at. The processor answers with an acknowledge, which clears the pending flag of the presented vector.

Arbitration works in two steps. A trap outranks every maskable source, and the lowest trap index wins among traps. Among maskable sources, only those that are enabled and whose priority is strictly above the processor's current level compete. The highest priority wins, and on a tie the lower vector number wins. Vector numbers 0 to 6 are the traps, and maskable source i uses vector 7 + i. All outputs come from one register stage, so every source has the same latency.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irqReq, irqVec, irqAddr and irqLevel are zero, and every pending flag, enable bit, priority and handler table entry is cleared, so a vector never written reports handler address 0.
- R2: A maskable source is presented only if its enable bit is 1 and its priority is strictly greater than cpuPrio. A priority of 0 is never presented. Its pending flag is latched whether or not it is enabled, and stays set until acknowledged.
- R3: Among eligible maskable sources, the one with the highest priority is presented.
- R4: Among eligible maskable sources of equal priority, the lowest vector number is presented.
- R5: A pending trap is presented regardless of cpuPrio and of any enable bit, and outranks every maskable source. A trap reports irqLevel 8, and a maskable source reports its own priority (1 to 7).
- R6: Trap t uses vector t (0 to 6), and among pending traps the lowest index is presented. Maskable source i uses vector 7 + i.
- R7: A configuration write takes cfgData, cfgIdx and cfgSel when cfgWe is high. cfgSel 0 writes cfgData[23:0] into the handler entry of vector cfgIdx. cfgSel 1 writes cfgData[0] to the enable bit of vector cfgIdx. cfgSel 2 writes cfgData[2:0] to its priority. cfgSel 3 changes nothing. irqAddr always equals the handler entry of irqVec.
- R8: A request line high at a clock edge is reflected on the outputs right after that same edge. A configuration write at one edge is reflected on the outputs after the next edge.
- R9: When cpuAck is high at an edge while irqReq is high, the pending flag of irqVec clears at that edge, and the outputs after that edge already show the next winner or idle. When irqReq is low, cpuAck has no effect.
- R10: If a source is acknowledged at the same edge where its request line is high, the new request wins and the source stays pending.
- R11: While irqReq is low, irqVec, irqAddr and irqLevel are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | NUM_SRC | Maskable request lines, bit i is vector 7 + i |
| trapReq | input | NUM_TRAP | Non-maskable trap lines, bit t is vector t |
| cpuPrio | input | 3 | Processor's current priority level |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | 0 handler entry, 1 enable, 2 priority, 3 none |
| cfgIdx | input | 7 | Vector number addressed by the write |
| cfgData | input | 24 | Write data |
| cpuAck | input | 1 | Processor acknowledge of the presented vector |
| irqReq | output | 1 | Request to the processor |
| irqVec | output | 7 | Presented vector number |
| irqAddr | output | 24 | Handler start address of the presented vector |
| irqLevel | output | 4 | Level won: 1 to 7 for maskable sources, 8 for traps |

## Verification
An acknowledge and a fresh request from the same source can land on the same edge. The bench provokes this by raising cpuAck and the request line of the presented source together. It expects that source to be presented again after that edge, and then to go idle after a following plain acknowledge. Acknowledges that arrive while a lower-level source is already pending are also judged, by checking that the next winner appears right after the clearing edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int VEC_W  = 7;
  localparam int ADDR_W = 24;
  localparam int PRIO_W = 3;
  localparam int LVL_W  = 4;
  localparam logic [LVL_W-1:0] TRAP_LVL = 4'd8;

  typedef enum logic [1:0] {
    SEL_TABLE  = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_PRIO   = 2'd2,
    SEL_NONE   = 2'd3
  } cfgSel_e;

  typedef struct packed {
    logic              tableWe;
    logic              enWe;
    logic              prioWe;
    logic              ackClr;
    logic [VEC_W-1:0]  cfgVec;
    logic [VEC_W-1:0]  ackVec;
    logic [ADDR_W-1:0] cfgData;
  } ctlStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_TRAP = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [VEC_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              cpuAck,
  input  logic              irqReq,
  input  logic [VEC_W-1:0]  irqVec,
  output ctlStrobe_t        ctl
);
  localparam int NUM_VEC = NUM_TRAP + NUM_SRC;
  localparam logic [VEC_W-1:0] VEC_LIMIT  = VEC_W'(NUM_VEC);
  localparam logic [VEC_W-1:0] FIRST_SRC  = VEC_W'(NUM_TRAP);

  cfgSel_e selKind;
  logic    inRange;
  logic    isSource;

  assign selKind  = cfgSel_e'(cfgSel);
  assign inRange  = cfgIdx < VEC_LIMIT;
  assign isSource = cfgIdx >= FIRST_SRC;

  always_comb begin
    ctl         = '0;
    ctl.cfgVec  = cfgIdx;
    ctl.cfgData = cfgData;
    ctl.ackVec  = irqVec;
    ctl.ackClr  = cpuAck && irqReq;
    if (cfgWe && inRange) begin
      unique case (selKind)
        SEL_TABLE:  ctl.tableWe = 1'b1;
        SEL_ENABLE: ctl.enWe    = isSource;
        SEL_PRIO:   ctl.prioWe  = isSource;
        default:    ;
      endcase
    end
  end

  // R7
  cfg_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.tableWe, ctl.enWe, ctl.prioWe}));
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_TRAP = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcReq,
  input  logic [NUM_TRAP-1:0] trapReq,
  input  logic [PRIO_W-1:0]   cpuPrio,
  input  ctlStrobe_t          ctl,
  output logic                irqReq,
  output logic [VEC_W-1:0]    irqVec,
  output logic [ADDR_W-1:0]   irqAddr,
  output logic [LVL_W-1:0]    irqLevel
);
  localparam int NUM_VEC = NUM_TRAP + NUM_SRC;
  localparam logic [VEC_W-1:0] FIRST_SRC = VEC_W'(NUM_TRAP);

  logic [NUM_VEC-1:0]  reqIn;
  logic [NUM_VEC-1:0]  pend;
  logic [NUM_VEC-1:0]  pendNext;
  logic [NUM_SRC-1:0]  srcEn;
  logic [PRIO_W-1:0]   srcPrio [NUM_SRC];
  logic [ADDR_W-1:0]   vecTab  [NUM_VEC];

  logic                winHit;
  logic [VEC_W-1:0]    winVec;
  logic [ADDR_W-1:0]   winAddr;
  logic [LVL_W-1:0]    winLvl;

  assign reqIn = {srcReq, trapReq};

  // Pending flags: a new request outranks a same-edge acknowledge.
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_pend
    localparam logic [VEC_W-1:0] VEC_ID = VEC_W'(v);
    logic clrHere;
    assign clrHere     = ctl.ackClr && (ctl.ackVec == VEC_ID);
    assign pendNext[v] = reqIn[v] | (pend[v] & ~clrHere);

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (clrHere && !reqIn[v]) |=> !pend[v]);
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      reqIn[v] |=> pend[v]);
  end

  // Two-level arbitration on the next pending state.
  always_comb begin
    logic             trapHit;
    logic             srcHit;
    logic [PRIO_W-1:0] bestPrio;
    logic [VEC_W-1:0]  trapVec;
    logic [VEC_W-1:0]  srcVec;
    logic [ADDR_W-1:0] trapAddr;
    logic [ADDR_W-1:0] srcAddr;
    trapHit  = 1'b0;
    srcHit   = 1'b0;
    bestPrio = '0;
    trapVec  = '0;
    srcVec   = '0;
    trapAddr = '0;
    srcAddr  = '0;
    for (int t = 0; t < NUM_TRAP; t++) begin
      if (!trapHit && pendNext[t]) begin
        trapHit  = 1'b1;
        trapVec  = VEC_W'(t);
        trapAddr = vecTab[t];
      end
    end
    for (int s = 0; s < NUM_SRC; s++) begin
      if (pendNext[NUM_TRAP+s] && srcEn[s] && (srcPrio[s] > cpuPrio)
          && (!srcHit || (srcPrio[s] > bestPrio))) begin
        srcHit   = 1'b1;
        bestPrio = srcPrio[s];
        srcVec   = VEC_W'(NUM_TRAP + s);
        srcAddr  = vecTab[NUM_TRAP+s];
      end
    end
    winHit  = trapHit | srcHit;
    winVec  = '0;
    winAddr = '0;
    winLvl  = '0;
    if (trapHit) begin
      winVec  = trapVec;
      winAddr = trapAddr;
      winLvl  = TRAP_LVL;
    end else if (srcHit) begin
      winVec  = srcVec;
      winAddr = srcAddr;
      winLvl  = {1'b0, bestPrio};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= '0;
      srcEn <= '0;
      for (int s = 0; s < NUM_SRC; s++) srcPrio[s] <= '0;
      for (int v = 0; v < NUM_VEC; v++) vecTab[v] <= '0;
    end else begin
      pend <= pendNext;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (ctl.enWe && ctl.cfgVec == VEC_W'(NUM_TRAP + s))
          srcEn[s] <= ctl.cfgData[0];
        if (ctl.prioWe && ctl.cfgVec == VEC_W'(NUM_TRAP + s))
          srcPrio[s] <= ctl.cfgData[PRIO_W-1:0];
      end
      for (int v = 0; v < NUM_VEC; v++) begin
        if (ctl.tableWe && ctl.cfgVec == VEC_W'(v))
          vecTab[v] <= ctl.cfgData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq   <= 1'b0;
      irqVec   <= '0;
      irqAddr  <= '0;
      irqLevel <= '0;
    end else begin
      irqReq   <= winHit;
      irqVec   <= winVec;
      irqAddr  <= winAddr;
      irqLevel <= winLvl;
    end
  end

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> (irqVec == '0 && irqAddr == '0 && irqLevel == '0));
  // R2
  above_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqLevel != TRAP_LVL) |-> (irqLevel > {1'b0, $past(cpuPrio)}));
  // R5
  trap_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((irqVec < FIRST_SRC) == (irqLevel == TRAP_LVL)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_TRAP = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcReq,
  input  logic [NUM_TRAP-1:0] trapReq,
  input  logic [2:0]          cpuPrio,
  input  logic                cfgWe,
  input  logic [1:0]          cfgSel,
  input  logic [6:0]          cfgIdx,
  input  logic [23:0]         cfgData,
  input  logic                cpuAck,
  output logic                irqReq,
  output logic [6:0]          irqVec,
  output logic [23:0]         irqAddr,
  output logic [3:0]          irqLevel
);
  ctlStrobe_t ctl;

  irqc_ctrl #(.NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgIdx(cfgIdx), .cfgData(cfgData), .cpuAck(cpuAck),
    .irqReq(irqReq), .irqVec(irqVec), .ctl(ctl)
  );

  irqc_datapath #(.NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP)) dp_i (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .trapReq(trapReq),
    .cpuPrio(cpuPrio), .ctl(ctl), .irqReq(irqReq), .irqVec(irqVec),
    .irqAddr(irqAddr), .irqLevel(irqLevel)
  );
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NS = 32;
  localparam int NT = 7;
  localparam int NV = NS + NT;

  typedef struct packed {
    logic        r;
    logic [6:0]  v;
    logic [23:0] a;
    logic [3:0]  l;
  } outItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcReq = '0;
  logic [NT-1:0] trapReq = '0;
  logic [2:0]    cpuPrio = '0;
  logic          cfgWe = 1'b0;
  logic [1:0]    cfgSel = '0;
  logic [6:0]    cfgIdx = '0;
  logic [23:0]   cfgData = '0;
  logic          cpuAck = 1'b0;
  logic          irqReq;
  logic [6:0]    irqVec;
  logic [23:0]   irqAddr;
  logic [3:0]    irqLevel;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [23:0] tabModel [NV];
  outItem_t expQ [$];
  string    tagQ [$];
  outItem_t eItem;
  outItem_t gItem;
  string    eTag;

  always #2.5 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(NS), .NUM_TRAP(NT)) dut_i (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .trapReq(trapReq),
    .cpuPrio(cpuPrio), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .cfgData(cfgData), .cpuAck(cpuAck), .irqReq(irqReq), .irqVec(irqVec),
    .irqAddr(irqAddr), .irqLevel(irqLevel)
  );

  // Monitor: compares outputs against the oldest expectation.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      eItem = expQ.pop_front();
      eTag  = tagQ.pop_front();
      gItem = '{r: irqReq, v: irqVec, a: irqAddr, l: irqLevel};
      checks++;
      if (gItem !== eItem) begin
        errors++;
        $display("FAIL %s: got req=%0d vec=%0d addr=%h lvl=%0d, expected req=%0d vec=%0d addr=%h lvl=%0d",
                 eTag, gItem.r, gItem.v, gItem.a, gItem.l, eItem.r, eItem.v, eItem.a, eItem.l);
      end
    end
  end

  task automatic pushExp(string tag, bit r, int v, int l);
    outItem_t it;
    it.r = r;
    it.v = r ? 7'(v) : 7'd0;
    it.a = r ? tabModel[v] : 24'd0;
    it.l = r ? 4'(l) : 4'd0;
    expQ.push_back(it);
    tagQ.push_back(tag);
  endtask

  // One edge, then expect the registered outputs.
  task automatic stepExp(string tag, bit r, int v, int l);
    @(posedge clk);
    pushExp(tag, r, v, l);
    @(negedge clk);
  endtask

  task automatic cfgWrite(int sel, int idx, int data);
    cfgWe = 1'b1; cfgSel = 2'(sel); cfgIdx = 7'(idx); cfgData = 24'(data);
    @(posedge clk);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setSrc(int s, int prio);
    cfgWrite(1, NT + s, 1);
    cfgWrite(2, NT + s, prio);
  endtask

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < NV; v++) tabModel[v] = 24'd0;
    @(negedge clk);
    stepExp("R1 during reset", 0, 0, 0);
    stepExp("R1 during reset", 0, 0, 0);
    rstN = 1'b1;
    stepExp("R1 after reset", 0, 0, 0);

    // Load handler table, leaving vector 6 unwritten.
    for (int v = 0; v < NV; v++) begin
      if (v != 6) begin
        tabModel[v] = 24'h010000 + 24'(v * 64);
        cfgWrite(0, v, int'(tabModel[v]));
      end
    end

    // R8 / R2: single source, latency and cpu level mask.
    setSrc(0, 3);
    srcReq[0] = 1'b1;
    stepExp("R8 request shown after one edge", 1, 7, 3);
    srcReq[0] = 1'b0;
    stepExp("R2 pending held after line drops", 1, 7, 3);
    cpuPrio = 3'd3;
    stepExp("R2 equal cpu level blocks", 0, 0, 0);
    cpuPrio = 3'd2;
    stepExp("R2 lower cpu level forwards", 1, 7, 3);
    cpuAck = 1'b1;
    stepExp("R9 acknowledge clears", 0, 0, 0);
    cpuAck = 1'b0;
    cpuPrio = 3'd0;

    // R9: acknowledge while idle is ignored.
    setSrc(1, 2);
    cpuPrio = 3'd5;
    srcReq[1] = 1'b1;
    stepExp("R2 below cpu level", 0, 0, 0);
    srcReq[1] = 1'b0;
    cpuAck = 1'b1;
    stepExp("R9 idle acknowledge", 0, 0, 0);
    cpuAck = 1'b0;
    cpuPrio = 3'd0;
    stepExp("R9 pending survives idle acknowledge", 1, 8, 2);
    cpuAck = 1'b1;
    stepExp("R9 clear", 0, 0, 0);
    cpuAck = 1'b0;

    // R2: disabled source latches pending, shown once enabled.
    cfgWrite(2, NT + 2, 7);
    srcReq[2] = 1'b1;
    stepExp("R2 disabled source", 0, 0, 0);
    srcReq[2] = 1'b0;
    cfgWrite(1, NT + 2, 1);
    stepExp("R2 enabled later", 1, 9, 7);
    cpuAck = 1'b1;
    stepExp("R9 clear", 0, 0, 0);
    cpuAck = 1'b0;
    cfgWrite(1, NT + 3, 1);
    srcReq[3] = 1'b1;
    stepExp("R2 priority zero", 0, 0, 0);
    srcReq[3] = 1'b0;

    // R3: highest priority first, then next on each acknowledge.
    setSrc(4, 2); setSrc(5, 6); setSrc(6, 4);
    srcReq[6:4] = 3'b111;
    stepExp("R3 highest priority", 1, 12, 6);
    srcReq[6:4] = 3'b000;
    cpuAck = 1'b1;
    stepExp("R3 second after ack", 1, 13, 4);
    stepExp("R3 third after ack", 1, 11, 2);
    stepExp("R9 drained", 0, 0, 0);
    cpuAck = 1'b0;

    // R4: equal priority, lower vector first.
    setSrc(8, 5); setSrc(9, 5); setSrc(10, 5);
    srcReq[10:8] = 3'b111;
    stepExp("R4 tie lowest vector", 1, 15, 5);
    srcReq[10:8] = 3'b000;
    cpuAck = 1'b1;
    stepExp("R4 tie next", 1, 16, 5);
    stepExp("R4 tie last", 1, 17, 5);
    stepExp("R9 drained", 0, 0, 0);
    cpuAck = 1'b0;

    // R5 / R6: traps.
    setSrc(11, 7);
    cpuPrio = 3'd7;
    srcReq[11] = 1'b1;
    stepExp("R2 cpu level 7 blocks all", 0, 0, 0);
    srcReq[11] = 1'b0;
    trapReq[4] = 1'b1;
    stepExp("R5 trap ignores cpu level", 1, 4, 8);
    trapReq[4] = 1'b0;
    cpuAck = 1'b1;
    stepExp("R5 trap cleared", 0, 0, 0);
    cpuAck = 1'b0;
    cpuPrio = 3'd0;
    stepExp("R5 maskable resumes", 1, 18, 7);
    trapReq[5] = 1'b1; trapReq[2] = 1'b1;
    stepExp("R6 lower trap wins", 1, 2, 8);
    trapReq = '0;
    cpuAck = 1'b1;
    stepExp("R6 next trap", 1, 5, 8);
    stepExp("R5 trap before level 7", 1, 18, 7);
    stepExp("R9 drained", 0, 0, 0);
    cpuAck = 1'b0;

    // R1: unwritten table entry reads zero.
    trapReq[6] = 1'b1;
    stepExp("R1 unwritten entry", 1, 6, 8);
    trapReq[6] = 1'b0;
    cpuAck = 1'b1;
    stepExp("R9 clear", 0, 0, 0);
    cpuAck = 1'b0;

    // R7: configuration port.
    cfgWrite(3, NT, 24'hABCDEF);
    srcReq[0] = 1'b1;
    stepExp("R7 select 3 no effect", 1, 7, 3);
    srcReq[0] = 1'b0;
    tabModel[7] = 24'h5A5A5A;
    cfgWrite(0, 7, 24'h5A5A5A);
    stepExp("R7 table rewrite", 1, 7, 3);
    cfgWrite(2, 7, 6);
    stepExp("R7 priority rewrite", 1, 7, 6);

    // R10: acknowledge and new request on the same source.
    cpuAck = 1'b1;
    srcReq[0] = 1'b1;
    stepExp("R10 new request wins", 1, 7, 6);
    srcReq[0] = 1'b0;
    stepExp("R9 plain acknowledge", 0, 0, 0);
    cpuAck = 1'b0;

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule